// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block holds the loads and stores of an out-of-order core in program order, from dispatch until retirement. Each operation takes a slot at the tail when it is dispatched. Its effective address is written into that slot later, once its register operands are ready and the address has been computed. The queue then decides which loads may go to the data cache ahead of older operations. It also holds every store until the core commits it.

A load becomes eligible only when every older store in the queue has a known address and none of those addresses falls in the same word as the load. Among the eligible loads, the oldest is offered to the cache each cycle. Stores never touch memory speculatively. When the commit input retires a store at the head, the store is emitted on the drain port. A flush cuts the queue back to a given slot, which discards all younger operations.

Top module: `lsq_disambig`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1, `disp_idx` is 0, `ld_req` is 0 and `st_valid` is 0.
- R2: Dispatch takes slots in ascending index order starting at `disp_idx`, wrapping modulo 16. `disp_ready` is 0 exactly while 16 entries are held, and a dispatch while it is 0 is ignored.
- R3: A load whose address has not been written is never requested. Once its address is written and nothing blocks it, it is requested with `ld_idx` set to its slot and `ld_addr` set to its address.
- R4: A load is not requested while any older store in the queue has an unwritten address.
- R5: A load is not requested while an older store's address matches its word address, which is address bits [31:2]. A store in a different word does not block it, and a younger store never blocks it.
- R6: When several loads are eligible, `ld_req` presents the oldest one in program order.
- R7: A load that is granted (`ld_req` and `ld_grant` both 1 at a clock edge) is never requested again.
- R8: `commit_valid` retires the head entry only if that entry is a store with a known address or a load that has been granted. Otherwise the commit is ignored and the entry stays.
- R9: A retired store appears on `st_valid`/`st_addr` in the cycle after its commit cycle. Consecutive commits drain stores one per cycle in program order.
- R10: A flush to a held slot `flush_idx` removes every younger entry and sets the next dispatch slot to `flush_idx+1`. During a flush cycle, dispatch and commit are ignored.
- R11: An address write to a slot that holds no entry is ignored. A later dispatch into that slot starts with an unknown address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch a new memory operation |
| disp_is_store | input | 1 | 1 for a store, 0 for a load |
| disp_ready | output | 1 | Queue has a free slot |
| disp_idx | output | 4 | Slot the next dispatch will take |
| addr_valid | input | 1 | Effective address write |
| addr_idx | input | 4 | Slot receiving the address |
| addr_value | input | 32 | Effective address |
| ld_req | output | 1 | An eligible load is offered to the cache |
| ld_idx | output | 4 | Slot of the offered load |
| ld_addr | output | 32 | Address of the offered load |
| ld_grant | input | 1 | Cache accepts the offered load |
| commit_valid | input | 1 | Core commits the head memory operation |
| st_valid | output | 1 | A committed store is drained to memory |
| st_addr | output | 32 | Address of the drained store |
| flush_valid | input | 1 | Discard entries younger than `flush_idx` |
| flush_idx | input | 4 | Youngest slot kept by the flush |

## Verification
A wrong age order or a stale blocking decision shows up as a load request on `ld_req`. This happens in the same cycle, because the eligibility scan is combinational from the stored state. A corrupted head, tail or count shows up at once on `disp_idx` or `disp_ready`. It shows up one cycle after a commit on `st_valid`/`st_addr`. An entry that was not really removed by a flush shows up later, as an unexpected request once an older store resolves. An address that lingers after a slot is reused does the same when the next load is dispatched into that slot. The directed scenarios drive each of these paths and sample in the cycle where the effect must first appear.

// File: rtl/lsq_disambig.sv
module lsq_disambig #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int OFFW  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  input  logic                     disp_is_store,
  output logic                     disp_ready,
  output logic [$clog2(DEPTH)-1:0] disp_idx,
  input  logic                     addr_valid,
  input  logic [$clog2(DEPTH)-1:0] addr_idx,
  input  logic [AW-1:0]            addr_value,
  output logic                     ld_req,
  output logic [$clog2(DEPTH)-1:0] ld_idx,
  output logic [AW-1:0]            ld_addr,
  input  logic                     ld_grant,
  input  logic                     commit_valid,
  output logic                     st_valid,
  output logic [AW-1:0]            st_addr,
  input  logic                     flush_valid,
  input  logic [$clog2(DEPTH)-1:0] flush_idx
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] ent_v, ent_st, ent_ak, ent_iss;
  logic [AW-1:0]    ent_addr [DEPTH];
  logic [IDXW-1:0]  head, tail;
  logic [CW-1:0]    cnt;
  logic             st_valid_q;
  logic [AW-1:0]    st_addr_q;

  logic             head_ok, pop, push, flush_act;
  logic [IDXW-1:0]  frel;
  logic [IDXW-1:0]  ci, cj;
  logic             cok;

  assign disp_ready = (cnt != CW'(DEPTH));
  assign disp_idx   = tail;
  assign flush_act  = flush_valid && ent_v[flush_idx];
  assign frel       = flush_idx - head;
  assign head_ok    = ent_v[head] && ent_ak[head] && (ent_st[head] || ent_iss[head]);
  assign pop        = commit_valid && head_ok && !flush_act;
  assign push       = disp_valid && disp_ready && !flush_act;
  assign ld_addr    = ent_addr[ld_idx];
  assign st_valid   = st_valid_q;
  assign st_addr    = st_addr_q;

  always_comb begin
    ld_req = 1'b0;
    ld_idx = '0;
    ci     = '0;
    cj     = '0;
    cok    = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      ci  = head + IDXW'(k);
      cok = ent_v[ci] && !ent_st[ci] && ent_ak[ci] && !ent_iss[ci];
      for (int m = 0; m < k; m++) begin
        cj = head + IDXW'(m);
        if (ent_v[cj] && ent_st[cj] &&
            (!ent_ak[cj] || ent_addr[cj][AW-1:OFFW] == ent_addr[ci][AW-1:OFFW]))
          cok = 1'b0;
      end
      if (cok && !ld_req) begin
        ld_req = 1'b1;
        ld_idx = ci;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v      <= '0;
      ent_st     <= '0;
      ent_ak     <= '0;
      ent_iss    <= '0;
      head       <= '0;
      tail       <= '0;
      cnt        <= '0;
      st_valid_q <= 1'b0;
      st_addr_q  <= '0;
      for (int i = 0; i < DEPTH; i++) ent_addr[i] <= '0;
    end else begin
      st_valid_q <= pop && ent_st[head];
      st_addr_q  <= ent_addr[head];
      if (addr_valid && ent_v[addr_idx]) begin
        ent_ak[addr_idx]   <= 1'b1;
        ent_addr[addr_idx] <= addr_value;
      end
      if (ld_req && ld_grant) ent_iss[ld_idx] <= 1'b1;
      if (pop) begin
        ent_v[head] <= 1'b0;
        head        <= head + 1'b1;
      end
      if (push) begin
        ent_v[tail]   <= 1'b1;
        ent_st[tail]  <= disp_is_store;
        ent_ak[tail]  <= 1'b0;
        ent_iss[tail] <= 1'b0;
        tail          <= tail + 1'b1;
      end
      if (flush_act) begin
        for (int i = 0; i < DEPTH; i++)
          if (IDXW'(IDXW'(i) - head) > frel) ent_v[i] <= 1'b0;
        tail <= flush_idx + 1'b1;
        cnt  <= CW'(frel) + 1'b1;
      end else begin
        cnt <= cnt + CW'(push) - CW'(pop);
      end
    end
  end
endmodule

// File: rtl/lsq_disambig_chk.sv
module lsq_disambig_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     disp_valid,
  input logic                     disp_ready,
  input logic [$clog2(DEPTH)-1:0] disp_idx,
  input logic                     ld_req,
  input logic [$clog2(DEPTH)-1:0] ld_idx,
  input logic                     ld_grant,
  input logic                     commit_valid,
  input logic                     st_valid,
  input logic                     flush_act,
  input logic [$clog2(DEPTH)-1:0] flush_idx
);
  localparam int IDXW = $clog2(DEPTH);

  a_r2_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && !flush_act) |=> disp_idx == IDXW'($past(disp_idx) + 1'b1));

  a_r10_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
    flush_act |=> disp_idx == IDXW'($past(flush_idx) + 1'b1));

  a_r9_drain_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(commit_valid));

  a_r7_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && ld_grant) |=> !(ld_req && ld_idx == $past(ld_idx)));
endmodule

bind lsq_disambig lsq_disambig_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_idx(disp_idx), .ld_req(ld_req), .ld_idx(ld_idx), .ld_grant(ld_grant),
  .commit_valid(commit_valid), .st_valid(st_valid), .flush_act(flush_act),
  .flush_idx(flush_idx)
);

// File: tb/lsq_disambig_tb_top.sv
module lsq_disambig_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 0, disp_is_store = 0;
  logic        disp_ready;
  logic [3:0]  disp_idx;
  logic        addr_valid = 0;
  logic [3:0]  addr_idx = 0;
  logic [31:0] addr_value = 0;
  logic        ld_req;
  logic [3:0]  ld_idx;
  logic [31:0] ld_addr;
  logic        ld_grant = 0, commit_valid = 0;
  logic        st_valid;
  logic [31:0] st_addr;
  logic        flush_valid = 0;
  logic [3:0]  flush_idx = 0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lsq_disambig dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_is_store(disp_is_store),
    .disp_ready(disp_ready), .disp_idx(disp_idx), .addr_valid(addr_valid),
    .addr_idx(addr_idx), .addr_value(addr_value), .ld_req(ld_req), .ld_idx(ld_idx),
    .ld_addr(ld_addr), .ld_grant(ld_grant), .commit_valid(commit_valid),
    .st_valid(st_valid), .st_addr(st_addr), .flush_valid(flush_valid), .flush_idx(flush_idx)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0; disp_valid = 0; addr_valid = 0; ld_grant = 0;
    commit_valid = 0; flush_valid = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic dispatch(input bit is_st);
    disp_valid = 1; disp_is_store = is_st;
    tick();
    disp_valid = 0;
  endtask

  task automatic write_addr(input logic [3:0] idx, input logic [31:0] a);
    addr_valid = 1; addr_idx = idx; addr_value = a;
    tick();
    addr_valid = 0;
  endtask

  task automatic grant_one();
    ld_grant = 1;
    tick();
    ld_grant = 0;
  endtask

  task automatic commit_one();
    commit_valid = 1;
    tick();
    commit_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check(disp_ready == 1, "R1 ready", disp_ready, 1);
    check(disp_idx == 0, "R1 idx", disp_idx, 0);
    check(ld_req == 0 && st_valid == 0, "R1 idle", {ld_req, st_valid}, 0);
  endtask

  task automatic t_order_full();
    do_reset();
    for (int k = 0; k < 16; k++) begin
      check(disp_idx == 4'(k), "R2 order", disp_idx, k);
      dispatch(0);
    end
    check(disp_ready == 0, "R2 full", disp_ready, 0);
    dispatch(1);
    write_addr(0, 32'h0);
    check(ld_req && ld_idx == 0, "R3 req after addr", ld_idx, 0);
    grant_one();
    commit_one();
    check(disp_ready == 1, "R2 one free", disp_ready, 1);
    check(disp_idx == 0, "R2 ignored while full", disp_idx, 0);
    dispatch(0);
    check(disp_ready == 0, "R2 full again", disp_ready, 0);
  endtask

  task automatic t_addr_unknown();
    do_reset();
    dispatch(0);
    check(ld_req == 0, "R3 no addr", ld_req, 0);
    write_addr(5, 32'h40);
    for (int k = 0; k < 5; k++) dispatch(0);
    check(ld_req == 0, "R11 stale addr", ld_req, 0);
    write_addr(0, 32'h80);
    check(ld_req && ld_idx == 0 && ld_addr == 32'h80, "R3 offer", ld_addr, 32'h80);
  endtask

  task automatic t_store_block();
    do_reset();
    dispatch(1); dispatch(0);
    write_addr(1, 32'h100);
    check(ld_req == 0, "R4 older store unknown", ld_req, 0);
    write_addr(0, 32'h104);
    check(ld_req && ld_idx == 1, "R5 other word", ld_idx, 1);
    do_reset();
    dispatch(1); dispatch(0);
    write_addr(1, 32'h100);
    write_addr(0, 32'h102);
    check(ld_req == 0, "R5 same word", ld_req, 0);
    do_reset();
    dispatch(0); dispatch(1);
    write_addr(0, 32'h200);
    check(ld_req && ld_idx == 0, "R5 younger store", ld_idx, 0);
  endtask

  task automatic t_oldest();
    do_reset();
    dispatch(0); dispatch(0); dispatch(0);
    write_addr(2, 32'h30);
    check(ld_req && ld_idx == 2, "R6 single", ld_idx, 2);
    write_addr(1, 32'h20);
    check(ld_req && ld_idx == 1 && ld_addr == 32'h20, "R6 oldest", ld_idx, 1);
    grant_one();
    check(ld_req && ld_idx == 2, "R7 next after grant", ld_idx, 2);
    grant_one();
    check(ld_req == 0, "R7 none left", ld_req, 0);
  endtask

  task automatic t_commit();
    do_reset();
    dispatch(1); dispatch(0);
    commit_one();
    check(st_valid == 0, "R8 unknown store held", st_valid, 0);
    write_addr(1, 32'h80);
    check(ld_req == 0, "R8 store still present", ld_req, 0);
    write_addr(0, 32'h40);
    check(ld_req && ld_idx == 1, "R8 load free", ld_idx, 1);
    commit_valid = 1;
    tick();
    commit_valid = 0;
    check(st_valid && st_addr == 32'h40, "R9 drain", st_addr, 32'h40);
    commit_one();
    check(st_valid == 0, "R9 single pulse", st_valid, 0);
    check(ld_req && ld_idx == 1, "R8 unissued load held", ld_idx, 1);
    do_reset();
    dispatch(1); dispatch(1);
    write_addr(0, 32'h10);
    write_addr(1, 32'h20);
    commit_valid = 1;
    tick();
    check(st_valid && st_addr == 32'h10, "R9 first", st_addr, 32'h10);
    tick();
    commit_valid = 0;
    check(st_valid && st_addr == 32'h20, "R9 second", st_addr, 32'h20);
    tick();
    check(st_valid == 0, "R9 done", st_valid, 0);
  endtask

  task automatic t_flush();
    do_reset();
    dispatch(1); dispatch(0); dispatch(0); dispatch(0);
    write_addr(2, 32'h10);
    write_addr(3, 32'h14);
    check(ld_req == 0, "R4 blocked before flush", ld_req, 0);
    flush_valid = 1; flush_idx = 1; disp_valid = 1; disp_is_store = 0; commit_valid = 1;
    tick();
    flush_valid = 0; disp_valid = 0; commit_valid = 0;
    check(disp_idx == 2, "R10 tail", disp_idx, 2);
    write_addr(0, 32'h500);
    check(ld_req == 0, "R10 younger removed", ld_req, 0);
    dispatch(0);
    check(ld_req == 0, "R10 reused slot no addr", ld_req, 0);
    write_addr(1, 32'h20);
    check(ld_req && ld_idx == 1, "R10 kept load", ld_idx, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_order_full();
        t_addr_unknown();
        t_store_block();
        t_oldest();
        t_commit();
        t_flush();
      end
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule